// File: doc/BRIEF.md
# I/O-Read-Triggered Watchdog Timer

This block is a watchdog timer that sits on a simple I/O bus. Software controls it only by reading two fixed 16-bit I/O addresses. No data moves. A read of the arm address while the timer is off turns it on and starts a fresh timeout period. Later reads of the same address restart the count. A read of the disarm address turns the timer off.

If the timeout period passes with no refresh, the block acts on expiry. It either drives a reset pulse to the CPU or raises a level interrupt request. A two-bit strap input, set like a pair of board jumpers, chooses the action and can remove the watchdog function entirely. The strap value 2'b00 is the default: watchdog present, reset action.

A prescaler divides the system clock into ticks. A second counter counts ticks up to a parameterised terminal count, which lets the period be trimmed over the tolerance range of the timer. With the default values and a 50 MHz clock, the period is 1.6 s.

Top module: `io_read_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed and both `cpu_reset` and `irq_out` are low.
- R2: A valid read of address 0x0443 arms a disarmed watchdog. With no further valid reads, the expiry output rises exactly CLK_PER_TICK*TIMEOUT_TICKS cycles after the clock edge that sampled the arming read.
- R3: While armed, each valid read of 0x0443 restarts the full timeout period from that read's edge.
- R4: A valid read of 0x0043 disarms the watchdog. No expiry output follows until 0x0443 is read again.
- R5: With `strap_mode[0]`=0 (reset action), expiry drives `cpu_reset` high for exactly RST_HOLD_CYCLES cycles. The watchdog is then disarmed, and `irq_out` stays low.
- R6: With `strap_mode[0]`=1 (interrupt action), expiry sets `irq_out` high, and `cpu_reset` stays low. `irq_out` stays high until a valid read of 0x0443 or 0x0043. A read of 0x0443 clears it and starts a fresh full period. A read of 0x0043 clears it and disarms the watchdog.
- R7: A valid read needs `io_rd`=1, `io_wr`=0 and a match on all 16 address bits. Writes, cycles with both strobes high, and reads of other addresses (for example 0x1443 or 0x0442) have no effect.
- R8: While `strap_mode[1]`=1, the watchdog is disarmed and ignores all reads, and both outputs are low. If it is armed when this bit rises, it stays disarmed after the bit clears.
- R9: Reads of either address during the reset pulse are ignored. The pulse keeps its full length, and the watchdog is disarmed afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| io_addr | input | 16 | I/O address of the current bus cycle |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe |
| strap_mode | input | 2 | Static strap: bit1 = 1 removes the watchdog function; bit0 selects the action, 0 = reset, 1 = interrupt |
| cpu_reset | output | 1 | CPU reset pulse on expiry in reset action |
| irq_out | output | 1 | Level interrupt request on expiry in interrupt action |

## Verification
The assertions assume that the strap changes only between bus accesses and that each read strobe lasts a single cycle. They also assume that CLK_PER_TICK*TIMEOUT_TICKS is larger than one, so that a refresh is always followed by at least one quiet cycle. The bench drives each access for exactly one clock and changes the strap only on idle cycles. Its random phase keeps refresh gaps below the period, then ends each round with a gap of exactly the period or one cycle less. Between accesses it adds non-matching reads and writes as noise.

// File: rtl/io_read_watchdog.sv
module io_read_watchdog #(
  parameter int          CLK_PER_TICK    = 50000,
  parameter int          TIMEOUT_TICKS   = 1600,
  parameter int          RST_HOLD_CYCLES = 64,
  parameter logic [15:0] ARM_ADDR        = 16'h0443,
  parameter logic [15:0] DISARM_ADDR     = 16'h0043
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [1:0]  strap_mode,
  output logic        cpu_reset,
  output logic        irq_out
);

  localparam int PW = (CLK_PER_TICK    > 1) ? $clog2(CLK_PER_TICK)    : 1;
  localparam int TW = (TIMEOUT_TICKS   > 1) ? $clog2(TIMEOUT_TICKS)   : 1;
  localparam int HW = (RST_HOLD_CYCLES > 1) ? $clog2(RST_HOLD_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(CLK_PER_TICK - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TIMEOUT_TICKS - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD_CYCLES - 1);

  typedef enum logic [1:0] {S_OFF, S_ARMED, S_RESET, S_IRQ} wd_state_t;

  wd_state_t     state;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tick_cnt;
  logic [HW-1:0] hold_cnt;

  wire rd_ok   = io_rd & ~io_wr;
  wire kick    = rd_ok & (io_addr == ARM_ADDR);
  wire stop    = rd_ok & (io_addr == DISARM_ADDR);
  wire wd_off  = strap_mode[1];
  wire use_irq = strap_mode[0];
  wire pre_end = (pre_cnt == PRE_LAST);
  wire expire  = pre_end & (tick_cnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_OFF;
      pre_cnt  <= '0;
      tick_cnt <= '0;
      hold_cnt <= '0;
    end else if (wd_off) begin
      state <= S_OFF;
    end else begin
      unique case (state)
        S_OFF: if (kick) begin
          state    <= S_ARMED;
          pre_cnt  <= '0;
          tick_cnt <= '0;
        end
        S_ARMED: begin
          if (stop) begin
            state <= S_OFF;
          end else if (kick) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
          end else if (expire) begin
            state    <= use_irq ? S_IRQ : S_RESET;
            pre_cnt  <= '0;
            hold_cnt <= '0;
          end else if (pre_end) begin
            pre_cnt  <= '0;
            tick_cnt <= tick_cnt + 1'b1;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        S_RESET: begin
          if (hold_cnt == HOLD_LAST) state <= S_OFF;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        S_IRQ: begin
          if (stop) begin
            state <= S_OFF;
          end else if (kick) begin
            state    <= S_ARMED;
            pre_cnt  <= '0;
            tick_cnt <= '0;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  assign cpu_reset = (state == S_RESET);
  assign irq_out   = (state == S_IRQ);

endmodule

// File: rtl/io_read_watchdog_chk.sv
module io_read_watchdog_chk #(
  parameter int          RST_HOLD_CYCLES = 64,
  parameter logic [15:0] ARM_ADDR        = 16'h0443,
  parameter logic [15:0] DISARM_ADDR     = 16'h0043
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [1:0]  strap_mode,
  input logic        cpu_reset,
  input logic        irq_out
);

  wire arm_rd = io_rd & ~io_wr & (io_addr == ARM_ADDR);
  wire dis_rd = io_rd & ~io_wr & (io_addr == DISARM_ADDR);

  int unsigned rst_run;
  always_ff @(posedge clk) begin
    if (!rst_n) rst_run <= 0;
    else if (cpu_reset) rst_run <= rst_run + 1;
    else rst_run <= 0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !cpu_reset && !irq_out);

  assert_kick_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_rd && !cpu_reset && !strap_mode[1] |=> !cpu_reset && !irq_out);

  assert_disarm_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dis_rd && !cpu_reset |=> !cpu_reset && !irq_out);

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> rst_run < RST_HOLD_CYCLES);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !arm_rd && !dis_rd && !strap_mode[1] |=> irq_out);

  assert_irq_no_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !cpu_reset);

  assert_strap_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_mode[1] |=> !cpu_reset && !irq_out);

  assert_pulse_ignores_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset && !strap_mode[1] && (rst_run + 1 < RST_HOLD_CYCLES) |=> cpu_reset);

endmodule

bind io_read_watchdog io_read_watchdog_chk #(
  .RST_HOLD_CYCLES(RST_HOLD_CYCLES),
  .ARM_ADDR(ARM_ADDR),
  .DISARM_ADDR(DISARM_ADDR)
) i_io_read_watchdog_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .strap_mode(strap_mode), .cpu_reset(cpu_reset), .irq_out(irq_out)
);

// File: tb/test_io_read_watchdog.sv
module test_io_read_watchdog;
  localparam int P  = 4;
  localparam int T  = 10;
  localparam int H  = 5;
  localparam int PT = P * T;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [1:0]  strap_mode = 2'b00;
  logic        cpu_reset, irq_out;

  int checks = 0;
  int errors = 0;

  io_read_watchdog #(.CLK_PER_TICK(P), .TIMEOUT_TICKS(T), .RST_HOLD_CYCLES(H)) i_io_read_watchdog (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .strap_mode(strap_mode), .cpu_reset(cpu_reset), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  function automatic bit expect_fire(int gap);
    return gap >= PT;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {cpu_reset,irq_out} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic noisy(int n);
    for (int i = 0; i < n; i++) begin
      case ($urandom % 5)
        0: begin io_wr = 1'b1; io_addr = 16'h0443; end
        1: begin io_rd = 1'b1; io_addr = 16'h1443; end
        2: begin io_rd = 1'b1; io_addr = 16'h0442; end
        3: begin io_wr = 1'b1; io_addr = 16'h0043; end
        default: ;
      endcase
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0; io_addr = '0;
    end
  endtask

  task automatic rd(logic [15:0] a);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_addr = '0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    idle(3);
    chk("R1 reset state", {cpu_reset, irq_out}, 2'b00);
    rst_n = 1'b1;
    idle(1);
    chk("R1 after release", {cpu_reset, irq_out}, 2'b00);

    noisy(PT + 5);
    io_addr = 16'h0443; io_rd = 1'b1; io_wr = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
    idle(PT + 2);
    chk("R7 writes and other addresses ignored", {cpu_reset, irq_out}, 2'b00);

    rd(16'h0443);
    idle(PT - 1);
    chk("R2 one cycle before expiry", {cpu_reset, irq_out}, 2'b00);
    idle(1);
    chk("R2 expiry cycle", {cpu_reset, irq_out}, 2'b10);
    idle(H - 1);
    chk("R5 last pulse cycle", {cpu_reset, irq_out}, 2'b10);
    idle(1);
    chk("R5 pulse ended", {cpu_reset, irq_out}, 2'b00);
    idle(PT + 5);
    chk("R5 disarmed after pulse", {cpu_reset, irq_out}, 2'b00);

    rd(16'h0443);
    idle(PT - 2);
    rd(16'h0443);
    idle(PT - 1);
    chk("R3 refresh restarts period", {cpu_reset, irq_out}, 2'b00);
    idle(1);
    chk("R3 expiry after refresh", {cpu_reset, irq_out}, 2'b10);
    idle(H);

    rd(16'h0443);
    idle(10);
    rd(16'h0043);
    idle(2 * PT);
    chk("R4 disarm prevents expiry", {cpu_reset, irq_out}, 2'b00);

    rd(16'h0443);
    idle(PT);
    chk("R9 pulse started", {cpu_reset, irq_out}, 2'b10);
    rd(16'h0443);
    rd(16'h0043);
    idle(H - 3);
    chk("R9 pulse kept length", {cpu_reset, irq_out}, 2'b10);
    idle(1);
    chk("R9 pulse ended on time", {cpu_reset, irq_out}, 2'b00);
    idle(PT + 2);
    chk("R9 reads during pulse did not arm", {cpu_reset, irq_out}, 2'b00);

    strap_mode = 2'b01;
    idle(1);
    rd(16'h0443);
    idle(PT);
    chk("R6 irq on expiry", {cpu_reset, irq_out}, 2'b01);
    idle(50);
    chk("R6 irq holds", {cpu_reset, irq_out}, 2'b01);
    rd(16'h0443);
    chk("R6 arm read clears irq", {cpu_reset, irq_out}, 2'b00);
    idle(PT - 1);
    chk("R6 fresh period after clear", {cpu_reset, irq_out}, 2'b00);
    idle(1);
    chk("R6 second expiry", {cpu_reset, irq_out}, 2'b01);
    rd(16'h0043);
    idle(PT + 3);
    chk("R6 disarm read clears and disarms", {cpu_reset, irq_out}, 2'b00);

    strap_mode = 2'b10;
    idle(1);
    rd(16'h0443);
    idle(PT + 5);
    chk("R8 strap off ignores arm", {cpu_reset, irq_out}, 2'b00);
    strap_mode = 2'b00;
    idle(1);
    rd(16'h0443);
    idle(5);
    strap_mode = 2'b10;
    idle(1);
    strap_mode = 2'b00;
    idle(PT + 5);
    chk("R8 strap off disarms", {cpu_reset, irq_out}, 2'b00);

    for (int it = 0; it < 25; it++) begin
      int g;
      int kicks;
      bit mode;
      bit fire;
      mode = 1'($urandom % 2);
      strap_mode = {1'b0, mode};
      idle(1);
      rd(16'h0443);
      kicks = 1 + int'($urandom % 4);
      for (int k = 0; k < kicks; k++) begin
        g = 1 + int'($urandom % (PT - 1));
        noisy(g);
        chk("R3 random refresh gap", {cpu_reset, irq_out}, 2'b00);
        rd(16'h0443);
      end
      g = PT - int'($urandom % 2);
      noisy(g);
      fire = expect_fire(g);
      if (mode) chk("R6 random final gap", {cpu_reset, irq_out}, {1'b0, fire});
      else      chk("R5 random final gap", {cpu_reset, irq_out}, {fire, 1'b0});
      if (fire && !mode) idle(H);
      else rd(16'h0043);
      chk("R4 random cleanup", {cpu_reset, irq_out}, 2'b00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule